// File: doc/BRIEF.md
# Pixel Colour Key Generator

This block decides, pixel by pixel, whether the RGB output shows the internally converted picture or an external video source. Graphics pixel bytes are compared against one programmable key byte. Pixels arrive in one of four formats:

- a single byte;
- two bytes on one lane, one on each clock edge;
- two bytes on one lane on consecutive rising edges;
- three bytes on three parallel lanes.

The graphics match is ORed with an external key input whose polarity can be inverted. The result is then delayed by a programmable number of pixel-clock cycles before it drives the output multiplexer select.

All configuration (format, key byte, polarity, delay) arrives on plain register inputs. A synchronous active-high reset empties the delay line and the byte-phase state. While reset is applied, the select points at the external video path.

Top module: `pixel_ckey_gen`

## Requirements
- R1: While `rst` is high at a rising edge, the edge clears all select state. `mix_sel` then reads 0 (the external video path) for every `sel_delay` setting, and the two-byte phase restarts at the first byte.
- R2: With `key_mode` = 3'b100, the graphics match is `pix_b0 == key_value`. `pix_b1` and `pix_b2` are ignored.
- R3: With `key_mode` = 3'b101, the value of `pix_b0` at each falling edge is held. At the next rising edge, the graphics match is true only if both the held byte and `pix_b0` equal `key_value`.
- R4: With `key_mode` = 3'b110, consecutive rising-edge bytes on `pix_b0` form a pixel. The first byte comes at the first edge after reset or after entering the mode. The match is evaluated at the second byte and held through the next pixel's first byte. Before any pixel has completed, the match is 0.
- R5: With `key_mode` = 3'b111, the graphics match is true only if `pix_b0`, `pix_b1` and `pix_b2` all equal `key_value`.
- R6: With `key_mode[2]` = 0, graphics keying is off, and only the external key can set the select.
- R7: The effective external key is `ext_key ^ ext_key_inv`. A 1 selects the converter path.
- R8: The select before the delay is the graphics match ORed with the effective external key.
- R9: The select formed from the inputs at a rising edge appears on `mix_sel` after that edge plus `sel_delay` (0 to 7) more rising edges. `mix_sel` = 1 means the converter path.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Pixel clock; both edges used in mode 101 |
| rst | input | 1 | Synchronous active-high reset |
| key_mode | input | 3 | Pixel format / keying enable |
| key_value | input | 8 | Key byte compared with every pixel byte |
| ext_key | input | 1 | External key input |
| ext_key_inv | input | 1 | Inverts the external key when 1 |
| sel_delay | input | 3 | Extra cycles of select delay (0-7) |
| pix_b0 | input | 8 | Pixel byte lane 0 (all modes) |
| pix_b1 | input | 8 | Pixel byte lane 1 (three-byte mode) |
| pix_b2 | input | 8 | Pixel byte lane 2 (three-byte mode) |
| mix_sel | output | 1 | Output multiplexer select, 1 = converter |

## Verification
The hardest situation to reach is a two-byte pixel whose bytes disagree. In the double-edge mode, that is a falling-edge byte that differs from the rising-edge byte that follows. In the rising-edge pairing mode, one byte of a pair differs while the match stays held across the pair boundary.

The bench drives a separate byte before each falling edge and each rising edge. Each byte equals the key about half the time, so paired matches and near misses both occur often. Random segments switch modes on the fly, and the model restarts the byte phase whenever the pairing mode is entered. Directed cases cover a single mismatching lane, the inverted external key and a lone pulse through the longest delay.

// File: rtl/pixel_ckey_gen.sv
module pixel_ckey_gen #(
  parameter int BYTE_W = 8,
  parameter int DLY_W  = 3
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [2:0]        key_mode,
  input  logic [BYTE_W-1:0] key_value,
  input  logic              ext_key,
  input  logic              ext_key_inv,
  input  logic [DLY_W-1:0]  sel_delay,
  input  logic [BYTE_W-1:0] pix_b0,
  input  logic [BYTE_W-1:0] pix_b1,
  input  logic [BYTE_W-1:0] pix_b2,
  output logic              mix_sel
);
  localparam int TAPS = 1 << DLY_W;
  localparam logic [2:0] M_ONE   = 3'b100;
  localparam logic [2:0] M_DEDGE = 3'b101;
  localparam logic [2:0] M_PAIR  = 3'b110;
  localparam logic [2:0] M_TRUE  = 3'b111;

  logic [BYTE_W-1:0] fall_q, first_q;
  logic              phase_q, pair_q;
  logic              gfx_match, ext_eff, sel_next;
  logic [TAPS-1:0]   line_q;

  wire b0_hit = (pix_b0 == key_value);
  wire b1_hit = (pix_b1 == key_value);
  wire b2_hit = (pix_b2 == key_value);
  wire pair_hit = (first_q == key_value) && b0_hit;

  always_ff @(negedge clk) begin
    if (rst) fall_q <= '0;
    else     fall_q <= pix_b0;
  end

  always_ff @(posedge clk) begin
    if (rst || key_mode != M_PAIR) begin
      phase_q <= 1'b0;
      pair_q  <= 1'b0;
      if (rst) first_q <= '0;
    end else begin
      phase_q <= ~phase_q;
      if (!phase_q) first_q <= pix_b0;
      else          pair_q  <= pair_hit;
    end
  end

  always_comb begin
    case (key_mode)
      M_ONE:   gfx_match = b0_hit;
      M_DEDGE: gfx_match = (fall_q == key_value) && b0_hit;
      M_PAIR:  gfx_match = phase_q ? pair_hit : pair_q;
      M_TRUE:  gfx_match = b0_hit && b1_hit && b2_hit;
      default: gfx_match = 1'b0;
    endcase
  end

  assign ext_eff  = ext_key ^ ext_key_inv;
  assign sel_next = gfx_match | ext_eff;

  always_ff @(posedge clk) begin
    if (rst) line_q <= '0;
    else     line_q <= {line_q[TAPS-2:0], sel_next};
  end

  assign mix_sel = line_q[sel_delay];

  p_reset_clears_r1: assert property (@(posedge clk) rst |=> !mix_sel);
  p_pair_phase_r4: assert property (@(posedge clk) disable iff (rst)
    (key_mode == M_PAIR && !phase_q) |=> phase_q);
  p_true_colour_r5: assert property (@(posedge clk) disable iff (rst)
    (key_mode == M_TRUE && b0_hit && b1_hit && b2_hit) |=> line_q[0]);
  p_keying_off_r6: assert property (@(posedge clk) disable iff (rst)
    (!key_mode[2] && !(ext_key ^ ext_key_inv)) |=> !line_q[0]);
  p_ext_forces_r7: assert property (@(posedge clk) disable iff (rst)
    (ext_key ^ ext_key_inv) |=> line_q[0]);
  p_tap_one_r9: assert property (@(posedge clk) disable iff (rst)
    (sel_delay == 1) |=> (sel_delay != 1 || mix_sel == $past(line_q[0])));
endmodule

// File: tb/pixel_ckey_gen_tb.sv
module pixel_ckey_gen_tb_top;
  logic clk = 0, rst = 1;
  logic [2:0] key_mode = 3'b100;
  logic [7:0] key_value = 8'h5a;
  logic ext_key = 0, ext_key_inv = 0;
  logic [2:0] sel_delay = 0;
  logic [7:0] pix_b0 = 0, pix_b1 = 0, pix_b2 = 0;
  logic mix_sel;

  int checks = 0, fails = 0;
  bit done = 0;
  logic [7:0] fall_m = 0, first_m = 0, hist_m = 0;
  logic phase_m = 0, pair_m = 0;

  always #4 clk = ~clk;

  pixel_ckey_gen dut_i (.clk, .rst, .key_mode, .key_value, .ext_key, .ext_key_inv,
                        .sel_delay, .pix_b0, .pix_b1, .pix_b2, .mix_sel);

  task automatic check(input string tag, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s: mix_sel=%0b expected %0b (mode=%b dly=%0d)", tag, act, exp, key_mode, sel_delay);
    end
  endtask

  function automatic string tag_for(input logic [2:0] m, input logic e);
    if (e) return "R7";
    case (m)
      3'b100: return "R2";
      3'b101: return "R3";
      3'b110: return "R4";
      3'b111: return "R5";
      default: return "R6";
    endcase
  endfunction

  task automatic model_edge();
    logic m;
    if (rst) begin
      phase_m = 0; pair_m = 0; first_m = 0; hist_m = 0;
    end else begin
      case (key_mode)
        3'b100: m = (pix_b0 == key_value);
        3'b101: m = (fall_m == key_value) && (pix_b0 == key_value);
        3'b110: m = phase_m ? ((first_m == key_value) && (pix_b0 == key_value)) : pair_m;
        3'b111: m = (pix_b0 == key_value) && (pix_b1 == key_value) && (pix_b2 == key_value);
        default: m = 0;
      endcase
      if (key_mode == 3'b110) begin
        if (!phase_m) first_m = pix_b0;
        else pair_m = m;
        phase_m = ~phase_m;
      end else begin
        phase_m = 0; pair_m = 0;
      end
      hist_m = {hist_m[6:0], m | (ext_key ^ ext_key_inv)};
    end
  endtask

  task automatic run_cycle(input logic [7:0] fb, b0, b1, b2, input logic ext, input string tag);
    #1 pix_b0 = fb;
    @(negedge clk);
    fall_m = rst ? 8'h00 : fb;
    #2 pix_b0 = b0; pix_b1 = b1; pix_b2 = b2; ext_key = ext;
    @(posedge clk);
    model_edge();
    #1 check(tag, mix_sel, hist_m[sel_delay]);
  endtask

  function automatic logic [7:0] rbyte();
    return ($urandom_range(1) == 1) ? key_value : 8'($urandom);
  endfunction

  initial begin
    void'($urandom(32'd1234));
    @(posedge clk); #1;
    for (int d = 0; d < 8; d++) begin
      sel_delay = 3'(d);
      run_cycle(key_value, key_value, key_value, key_value, 1'b1, "R1");
    end
    rst = 0;
    key_mode = 3'b111; sel_delay = 0;
    run_cycle(0, key_value, key_value, key_value, 0, "R5");
    run_cycle(0, key_value, key_value, 8'h00, 0, "R5");
    run_cycle(0, key_value, 8'h01, key_value, 0, "R5");
    key_mode = 3'b101;
    run_cycle(8'h11, key_value, 0, 0, 0, "R3");
    run_cycle(key_value, key_value, 0, 0, 0, "R3");
    run_cycle(key_value, 8'h22, 0, 0, 0, "R3");
    key_mode = 3'b100;
    run_cycle(0, key_value, 8'h00, 8'h00, 0, "R2");
    key_mode = 3'b011;
    run_cycle(key_value, key_value, key_value, key_value, 0, "R6");
    ext_key_inv = 1;
    run_cycle(0, 0, 0, 0, 0, "R7");
    run_cycle(0, 0, 0, 0, 1, "R7");
    ext_key_inv = 0; key_mode = 3'b100;
    run_cycle(0, 8'h00, 0, 0, 1, "R8");
    sel_delay = 7;
    run_cycle(0, key_value, 0, 0, 0, "R9");
    for (int i = 0; i < 9; i++) run_cycle(0, 8'h00, 0, 0, 0, "R9");
    key_mode = 3'b110; sel_delay = 0;
    run_cycle(0, key_value, 0, 0, 0, "R4");
    run_cycle(0, key_value, 0, 0, 0, "R4");
    run_cycle(0, key_value, 0, 0, 0, "R4");
    run_cycle(0, 8'h33, 0, 0, 0, "R4");
    run_cycle(0, key_value, 0, 0, 0, "R4");
    for (int s = 0; s < 40; s++) begin
      key_mode = 3'($urandom);
      sel_delay = 3'($urandom);
      ext_key_inv = 1'($urandom);
      key_value = 8'($urandom);
      if (s % 9 == 4) begin
        rst = 1;
        run_cycle(0, 0, 0, 0, 0, "R1");
        rst = 0;
      end
      for (int c = 0; c < 60; c++) begin
        logic e;
        e = ($urandom_range(7) == 0);
        run_cycle(rbyte(), rbyte(), rbyte(), rbyte(), e ^ ext_key_inv,
                  tag_for(key_mode, !(e ^ ext_key_inv) ? 1'b0 : 1'b1));
      end
    end
    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    #(8 * 150000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: run did not complete, actual hung expected done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule